// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block brings an attached Ethernet PHY from an unknown condition to a negotiated link. It has no serial management logic of its own. Instead it drives a transaction request port, which a separate management-frame engine serves. That port carries an address, a register number, write data, a write flag and a start strobe, and it returns a done strobe with read data. One pulse on the start input runs the whole bring-up without further help, and the block then reports a result code.

The run follows a fixed order:
1. Soft-reset the PHY and poll until the reset bit clears.
2. Silence every PHY interrupt source.
3. Read the PHY's ability bits and turn them into an advertisement word.
4. Write the advertisement and kick off autonegotiation.
5. Poll for completion.

A poll that sees a remote fault forces a renegotiation with the speed and duplex bits set. Both polling loops are bounded by attempt counts. Polls are spaced by an interval taken from a prescaler, so a short interval can replace the half-second default.

States and transitions:
- IDLE moves to RST_WR on start.
- RST_WR moves to RST_RD when its write completes.
- RST_RD moves to MASK_WR if the reset bit is clear. If the bit is still set it moves to RST_GAP, or to FINISH once the attempts are used up.
- RST_GAP returns to RST_RD on the interval tick.
- MASK_WR moves to CAP_RD, CAP_RD to ADV_WR, ADV_WR to ANEG_WR and ANEG_WR to POLL_RD, each on completion of its transaction.
- POLL_RD moves to FINISH when negotiation is complete. Otherwise it moves to FLT_WR if a fault is seen, to POLL_GAP, or to FINISH when the attempts are exhausted.
- FLT_WR moves to POLL_GAP, or to FINISH on the last attempt.
- POLL_GAP returns to POLL_RD on the tick.
- FINISH returns to IDLE.

Top module: `phy_link_sequencer`

## Requirements
- R1: After reset `busy_o`, `done_o`, `ok_o` and `mgmt_start_o` are low and `code_o` is 0 (no result).
- R2: A start pulse while idle begins a run whose first request writes the control register (register 0) with 16'h8000 (bit 15, reset, alone). A start pulse during a run is ignored and the run's request sequence is unchanged.
- R3: At most one request is outstanding. The request fields stay constant from `mgmt_start_o` until `mgmt_done_i`, and every request carries `PHY_ADDR`.
- R4: Reset polling reads register 0 at most `RESET_POLLS` times. The first read with bit 15 clear ends the wait. If all reads show bit 15 set, the run ends with code 2 (reset timeout).
- R5: Each poll after the first in a loop is requested exactly `TICK_CYCLES`+1 cycles after the done of the preceding request. Every other request is issued in the cycle after the preceding done.
- R6: After the reset clears, 16'hFFFF is written to register `MASK_REG`.
- R7: Register 1 is then read and 16'h0001 is written to register 4. For each of status bits 15, 14, 13, 12 and 11, the write also sets advertisement bit 9, 8, 7, 6 or 5 respectively. No other status bit affects the word.
- R8: After the advertisement, register 0 is written with 16'h1200 (enable bit 12, restart bit 9).
- R9: Negotiation polling reads register 1 at most `ANEG_POLLS` times. A read with bit 5 set ends the run with code 1 (success) if bit 4 is clear, or code 4 (remote fault) if bit 4 is set.
- R10: A poll with bit 5 clear and bit 4 set is followed at once by a write of 16'h3300 to register 0 (bits 13, 12, 9, 8).
- R11: If the last allowed poll lacks bit 5, the run ends with code 4 when that poll had bit 4 set and with code 3 (negotiation timeout) otherwise.
- R12: The run ends with a single-cycle `done_o` pulse. `busy_o` is high from the cycle after start through that pulse. `code_o` and `ok_o` hold until the next accepted start, and `ok_o` is high exactly when the code is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a bring-up run (used only while idle) |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| ok_o | output | 1 | Last run succeeded |
| code_o | output | 3 | Result: 0 none, 1 success, 2 reset timeout, 3 negotiation timeout, 4 remote fault |
| mgmt_start_o | output | 1 | Request strobe to the management engine |
| mgmt_write_o | output | 1 | Request is a write |
| mgmt_phy_o | output | 5 | PHY address of the request |
| mgmt_reg_o | output | 5 | PHY register number of the request |
| mgmt_wdata_o | output | 16 | Write data of the request |
| mgmt_done_i | input | 1 | Request completed |
| mgmt_rdata_i | input | 16 | Read data, valid with `mgmt_done_i` |

## Verification
The bound checker watches the request handshake on every cycle. It confirms that only one request is in flight, that fields stay stable and the PHY address is fixed, and that control writes use only the three legal words. It also checks that `done_o` is a single pulse with a non-zero code and that busy falls only through done. The order of requests, the advertisement word, the retry bounds, the remote-fault restarts, the exact poll spacing and the choice among the four result codes depend on what the PHY answers. Only the bench's scenarios can show these, by comparing the logged request stream against an expected stream built from the requirements.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    // PHY register numbers decoded by the PHY itself
    localparam logic [ADDR_W-1:0] REG_CTRL = 5'd0;
    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;

    // Control register words
    localparam logic [DATA_W-1:0] CTRL_SOFT_RESET = 16'h8000;
    localparam logic [DATA_W-1:0] CTRL_ANEG_KICK  = 16'h1200;
    localparam logic [DATA_W-1:0] CTRL_ANEG_FORCE = 16'h3300;
    localparam logic [DATA_W-1:0] MASK_ALL_SRC    = 16'hFFFF;
    localparam logic [DATA_W-1:0] ADV_SELECTOR    = 16'h0001;

    // Bit positions
    localparam int CTRL_RESET_BIT = 15;
    localparam int STAT_DONE_BIT  = 5;
    localparam int STAT_FAULT_BIT = 4;
    localparam int STAT_CAP_TOP   = 15;
    localparam int ADV_CAP_TOP    = 9;
    localparam int CAP_COUNT      = 5;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_WR,
        S_RST_RD,
        S_RST_GAP,
        S_MASK_WR,
        S_CAP_RD,
        S_ADV_WR,
        S_ANEG_WR,
        S_POLL_RD,
        S_FLT_WR,
        S_POLL_GAP,
        S_FINISH
    } seq_state_e;

    typedef enum logic [2:0] {
        RES_NONE     = 3'd0,
        RES_OK       = 3'd1,
        RES_RST_TMO  = 3'd2,
        RES_ANEG_TMO = 3'd3,
        RES_FAULT    = 3'd4
    } seq_result_e;

    // Status ability bits map one to one onto advertisement bits
    function automatic logic [DATA_W-1:0] adv_from_status(input logic [DATA_W-1:0] stat);
        logic [DATA_W-1:0] adv;
        adv = ADV_SELECTOR;
        for (int i = 0; i < CAP_COUNT; i++) begin
            adv[ADV_CAP_TOP-i] = stat[STAT_CAP_TOP-i];
        end
        return adv;
    endfunction

endpackage

// File: rtl/phy_seq_interval.sv
module phy_seq_interval #(
    parameter int unsigned TICK_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = en_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_seq_tries.sv
module phy_seq_tries #(
    parameter int unsigned LIMIT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic last_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign last_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && !last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/phy_seq_txn.sv
module phy_seq_txn (
    input  logic clk,
    input  logic rst_n,
    input  logic want_i,
    input  logic done_i,
    output logic issue_o,
    output logic accept_o
);
    logic pending_q;

    assign issue_o  = want_i && !pending_q;
    assign accept_o = pending_q && done_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
        end else if (issue_o) begin
            pending_q <= 1'b1;
        end else if (accept_o) begin
            pending_q <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_link_sequencer.sv
module phy_link_sequencer
    import phy_seq_pkg::*;
#(
    parameter logic [4:0]  PHY_ADDR    = 5'd0,
    parameter logic [4:0]  MASK_REG    = 5'd19,
    parameter int unsigned TICK_CYCLES = 50_000_000,
    parameter int unsigned RESET_POLLS = 6,
    parameter int unsigned ANEG_POLLS  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o,
    output logic [2:0]        code_o,
    output logic              mgmt_start_o,
    output logic              mgmt_write_o,
    output logic [ADDR_W-1:0] mgmt_phy_o,
    output logic [ADDR_W-1:0] mgmt_reg_o,
    output logic [DATA_W-1:0] mgmt_wdata_o,
    input  logic              mgmt_done_i,
    input  logic [DATA_W-1:0] mgmt_rdata_i
);
    seq_state_e        state_q, state_d;
    seq_result_e       result_q, result_d;
    logic [DATA_W-1:0] adv_q, adv_d;

    logic want_txn, accept, gap_en, tick;
    logic rst_clr, rst_inc, rst_last;
    logic neg_clr, neg_inc, neg_last;

    logic unused_rdata_bits;
    assign unused_rdata_bits = ^{mgmt_rdata_i[14:11], mgmt_rdata_i[10:6], mgmt_rdata_i[3:0]};

    phy_seq_txn txn_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_i  (want_txn),
        .done_i  (mgmt_done_i),
        .issue_o (mgmt_start_o),
        .accept_o(accept)
    );

    phy_seq_interval #(.TICK_CYCLES(TICK_CYCLES)) interval_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (gap_en),
        .tick_o(tick)
    );

    phy_seq_tries #(.LIMIT(RESET_POLLS)) rst_tries_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (rst_clr),
        .inc_i (rst_inc),
        .last_o(rst_last)
    );

    phy_seq_tries #(.LIMIT(ANEG_POLLS)) neg_tries_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (neg_clr),
        .inc_i (neg_inc),
        .last_o(neg_last)
    );

    // Next-state and result decisions
    always_comb begin
        state_d  = state_q;
        result_d = result_q;
        adv_d    = adv_q;
        rst_clr  = 1'b0;
        rst_inc  = 1'b0;
        neg_clr  = 1'b0;
        neg_inc  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d  = S_RST_WR;
                    result_d = RES_NONE;
                    rst_clr  = 1'b1;
                    neg_clr  = 1'b1;
                end
            end
            S_RST_WR: begin
                if (accept) state_d = S_RST_RD;
            end
            S_RST_RD: begin
                if (accept) begin
                    if (!mgmt_rdata_i[CTRL_RESET_BIT]) begin
                        state_d = S_MASK_WR;
                    end else if (rst_last) begin
                        state_d  = S_FINISH;
                        result_d = RES_RST_TMO;
                    end else begin
                        state_d = S_RST_GAP;
                        rst_inc = 1'b1;
                    end
                end
            end
            S_RST_GAP: begin
                if (tick) state_d = S_RST_RD;
            end
            S_MASK_WR: begin
                if (accept) state_d = S_CAP_RD;
            end
            S_CAP_RD: begin
                if (accept) begin
                    state_d = S_ADV_WR;
                    adv_d   = adv_from_status(mgmt_rdata_i);
                end
            end
            S_ADV_WR: begin
                if (accept) state_d = S_ANEG_WR;
            end
            S_ANEG_WR: begin
                if (accept) state_d = S_POLL_RD;
            end
            S_POLL_RD: begin
                if (accept) begin
                    if (mgmt_rdata_i[STAT_DONE_BIT]) begin
                        state_d  = S_FINISH;
                        result_d = mgmt_rdata_i[STAT_FAULT_BIT] ? RES_FAULT : RES_OK;
                    end else if (mgmt_rdata_i[STAT_FAULT_BIT]) begin
                        state_d = S_FLT_WR;
                    end else if (neg_last) begin
                        state_d  = S_FINISH;
                        result_d = RES_ANEG_TMO;
                    end else begin
                        state_d = S_POLL_GAP;
                        neg_inc = 1'b1;
                    end
                end
            end
            S_FLT_WR: begin
                if (accept) begin
                    if (neg_last) begin
                        state_d  = S_FINISH;
                        result_d = RES_FAULT;
                    end else begin
                        state_d = S_POLL_GAP;
                        neg_inc = 1'b1;
                    end
                end
            end
            S_POLL_GAP: begin
                if (tick) state_d = S_POLL_RD;
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            result_q <= RES_NONE;
            adv_q    <= ADV_SELECTOR;
        end else begin
            state_q  <= state_d;
            result_q <= result_d;
            adv_q    <= adv_d;
        end
    end

    // Outputs from the current state
    always_comb begin
        want_txn     = 1'b0;
        mgmt_write_o = 1'b0;
        mgmt_reg_o   = REG_CTRL;
        mgmt_wdata_o = '0;
        gap_en       = 1'b0;
        unique case (state_q)
            S_RST_WR: begin
                want_txn     = 1'b1;
                mgmt_write_o = 1'b1;
                mgmt_wdata_o = CTRL_SOFT_RESET;
            end
            S_RST_RD: begin
                want_txn = 1'b1;
            end
            S_MASK_WR: begin
                want_txn     = 1'b1;
                mgmt_write_o = 1'b1;
                mgmt_reg_o   = MASK_REG;
                mgmt_wdata_o = MASK_ALL_SRC;
            end
            S_CAP_RD, S_POLL_RD: begin
                want_txn   = 1'b1;
                mgmt_reg_o = REG_STAT;
            end
            S_ADV_WR: begin
                want_txn     = 1'b1;
                mgmt_write_o = 1'b1;
                mgmt_reg_o   = REG_ADV;
                mgmt_wdata_o = adv_q;
            end
            S_ANEG_WR: begin
                want_txn     = 1'b1;
                mgmt_write_o = 1'b1;
                mgmt_wdata_o = CTRL_ANEG_KICK;
            end
            S_FLT_WR: begin
                want_txn     = 1'b1;
                mgmt_write_o = 1'b1;
                mgmt_wdata_o = CTRL_ANEG_FORCE;
            end
            S_RST_GAP, S_POLL_GAP: begin
                gap_en = 1'b1;
            end
            default: begin
                want_txn = 1'b0;
            end
        endcase
    end

    assign mgmt_phy_o = PHY_ADDR;
    assign busy_o     = (state_q != S_IDLE);
    assign done_o     = (state_q == S_FINISH);
    assign code_o     = result_q;
    assign ok_o       = (result_q == RES_OK);

endmodule

// File: rtl/phy_link_seq_checker.sv
module phy_link_seq_checker #(
    parameter logic [4:0] PHY_ADDR = 5'd0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        busy_o,
    input logic        done_o,
    input logic        ok_o,
    input logic [2:0]  code_o,
    input logic        mgmt_start_o,
    input logic        mgmt_write_o,
    input logic [4:0]  mgmt_phy_o,
    input logic [4:0]  mgmt_reg_o,
    input logic [15:0] mgmt_wdata_o,
    input logic        mgmt_done_i
);
    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (mgmt_start_o) begin
            out_q <= 1'b1;
        end else if (mgmt_done_i) begin
            out_q <= 1'b0;
        end
    end

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start_o |-> !out_q);

    p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> $stable({mgmt_write_o, mgmt_reg_o, mgmt_wdata_o, mgmt_phy_o}));

    p_phy_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_start_o |-> (mgmt_phy_o == PHY_ADDR));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mgmt_start_o);

    // R2 R8 R10: control writes use only the three legal words
    p_ctrl_word_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_start_o && mgmt_write_o && mgmt_reg_o == 5'd0) |->
        (mgmt_wdata_o == 16'h8000 || mgmt_wdata_o == 16'h1200 || mgmt_wdata_o == 16'h3300));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (code_o != 3'd0 && ok_o == (code_o == 3'd1)));

    p_busy_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done_o));

endmodule

bind phy_link_sequencer phy_link_seq_checker #(.PHY_ADDR(PHY_ADDR)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .ok_o        (ok_o),
    .code_o      (code_o),
    .mgmt_start_o(mgmt_start_o),
    .mgmt_write_o(mgmt_write_o),
    .mgmt_phy_o  (mgmt_phy_o),
    .mgmt_reg_o  (mgmt_reg_o),
    .mgmt_wdata_o(mgmt_wdata_o),
    .mgmt_done_i (mgmt_done_i)
);

// File: tb/phy_link_sequencer_tb.sv
`timescale 1ns/1ps
module phy_link_sequencer_tb_top;
    localparam int         TK = 8;
    localparam int         RP = 6;
    localparam int         AP = 20;
    localparam logic [4:0] PA = 5'd3;
    localparam logic [4:0] MR = 5'd19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        busy_o, done_o, ok_o;
    logic [2:0]  code_o;
    logic        mgmt_start_o, mgmt_write_o;
    logic [4:0]  mgmt_phy_o, mgmt_reg_o;
    logic [15:0] mgmt_wdata_o;
    logic        mgmt_done_i = 1'b0;
    logic [15:0] mgmt_rdata_i = 16'h0;

    always #2 clk = ~clk;

    phy_link_sequencer #(
        .PHY_ADDR(PA), .MASK_REG(MR), .TICK_CYCLES(TK),
        .RESET_POLLS(RP), .ANEG_POLLS(AP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .code_o(code_o),
        .mgmt_start_o(mgmt_start_o), .mgmt_write_o(mgmt_write_o),
        .mgmt_phy_o(mgmt_phy_o), .mgmt_reg_o(mgmt_reg_o),
        .mgmt_wdata_o(mgmt_wdata_o), .mgmt_done_i(mgmt_done_i),
        .mgmt_rdata_i(mgmt_rdata_i)
    );

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 0;
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // scenario configuration
    int          sc_rst_hold, sc_cmp_at, sc_lat;
    logic [31:0] sc_fault;
    logic [15:0] sc_caps;
    bit          sc_poke;

    // request log filled by the PHY model
    bit          lg_write [64];
    logic [4:0]  lg_reg   [64];
    logic [4:0]  lg_phy   [64];
    logic [15:0] lg_wdata [64];
    longint      lg_start [64];
    longint      lg_done  [64];
    int          lg_n;

    // expected stream
    bit          ex_write [64];
    logic [4:0]  ex_reg   [64];
    logic [15:0] ex_wdata [64];
    bit          ex_gap   [64];
    int          ex_n;
    int          ex_code;

    int          ctrl_reads, stat_reads, pend_cnt, pend_idx;
    logic [15:0] pend_data;

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!cond) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_adv(input logic [15:0] s);
        logic [15:0] a;
        a = 16'h0001;
        if (s[15]) a = a | 16'h0200;
        if (s[14]) a = a | 16'h0100;
        if (s[13]) a = a | 16'h0080;
        if (s[12]) a = a | 16'h0040;
        if (s[11]) a = a | 16'h0020;
        return a;
    endfunction

    function automatic bit fault_at(input int p);
        return (p < 32) ? sc_fault[p] : 1'b0;
    endfunction

    task automatic push(input bit w, input logic [4:0] r, input logic [15:0] d, input bit g);
        ex_write[ex_n] = w;
        ex_reg[ex_n]   = r;
        ex_wdata[ex_n] = d;
        ex_gap[ex_n]   = g;
        ex_n++;
    endtask

    // Expected request stream from R2, R4, R6-R11
    task automatic build_expected();
        ex_n = 0;
        ex_code = 0;
        push(1, 5'd0, 16'h8000, 0);
        for (int i = 0; i < RP; i++) begin
            push(0, 5'd0, 16'h0, i > 0);
            if (i >= sc_rst_hold) break;
            if (i == RP - 1) begin
                ex_code = 2;
                return;
            end
        end
        push(1, MR, 16'hFFFF, 0);
        push(0, 5'd1, 16'h0, 0);
        push(1, 5'd4, exp_adv(sc_caps), 0);
        push(1, 5'd0, 16'h1200, 0);
        for (int p = 0; p < AP; p++) begin
            push(0, 5'd1, 16'h0, p > 0);
            if (p >= sc_cmp_at) begin
                ex_code = fault_at(p) ? 4 : 1;
                return;
            end
            if (fault_at(p)) push(1, 5'd0, 16'h3300, 0);
            if (p == AP - 1) begin
                ex_code = fault_at(p) ? 4 : 3;
                return;
            end
        end
    endtask

    // PHY model and management responder
    initial begin
        forever begin
            @(negedge clk);
            mgmt_done_i = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    mgmt_done_i  = 1'b1;
                    mgmt_rdata_i = pend_data;
                    lg_done[pend_idx] = cyc;
                end
            end
            if (mgmt_start_o && lg_n < 64) begin
                lg_write[lg_n] = mgmt_write_o;
                lg_reg[lg_n]   = mgmt_reg_o;
                lg_phy[lg_n]   = mgmt_phy_o;
                lg_wdata[lg_n] = mgmt_wdata_o;
                lg_start[lg_n] = cyc;
                pend_idx = lg_n;
                lg_n++;
                pend_cnt = sc_lat;
                pend_data = 16'h0;
                if (!mgmt_write_o && mgmt_reg_o == 5'd0) begin
                    ctrl_reads++;
                    pend_data = (ctrl_reads <= sc_rst_hold) ? (sc_caps | 16'h8000)
                                                            : (sc_caps & 16'h7FFF);
                end else if (!mgmt_write_o && mgmt_reg_o == 5'd1) begin
                    if (stat_reads == 0) begin
                        pend_data = sc_caps;
                    end else begin
                        pend_data = (sc_caps & 16'hFFCF)
                                  | ((stat_reads - 1 >= sc_cmp_at) ? 16'h0020 : 16'h0)
                                  | (fault_at(stat_reads - 1) ? 16'h0010 : 16'h0);
                    end
                    stat_reads++;
                end
            end
        end
    end

    task automatic run_scenario(input string tag);
        int k;
        int bad;
        int lim;
        bit got;
        logic [2:0] held;
        ctrl_reads = 0;
        stat_reads = 0;
        lg_n = 0;
        build_expected();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R12", {tag, " busy after start"}, busy_o, 1);
        got = 0;
        for (k = 0; k < 5000; k++) begin
            start_i = (sc_poke && k == 6);   // R2: ignored while busy
            @(negedge clk);
            if (done_o) begin
                got = 1;
                break;
            end
        end
        start_i = 1'b0;
        check(got, "R12", {tag, " done seen"}, got, 1);
        // R4 R9 R11 result code
        check(code_o == 3'(ex_code), "R4 R9 R11", {tag, " code"}, code_o, ex_code);
        check(ok_o == (ex_code == 1), "R12", {tag, " ok"}, ok_o, ex_code == 1);
        @(negedge clk);
        check(done_o == 1'b0 && busy_o == 1'b0, "R12", {tag, " done single pulse"}, done_o, 0);
        held = code_o;
        repeat (5) @(negedge clk);
        check(code_o == held && code_o == 3'(ex_code), "R12", {tag, " code held"}, code_o, ex_code);
        // R2 R3 R6 R7 R8 R10 request stream
        bad = (lg_n != ex_n) ? 1 : 0;
        lim = (lg_n < ex_n) ? lg_n : ex_n;
        for (int i = 0; i < lim; i++) begin
            if (lg_write[i] != ex_write[i] || lg_reg[i] != ex_reg[i] || lg_phy[i] != PA) bad++;
            if (ex_write[i] && lg_wdata[i] != ex_wdata[i]) bad++;
        end
        check(bad == 0, "R2 R3 R6 R7 R8 R10", {tag, " request stream count"}, lg_n, ex_n);
        // R5 spacing
        bad = 0;
        for (int i = 1; i < lim; i++) begin
            if (lg_start[i] - lg_done[i-1] != (ex_gap[i] ? TK + 1 : 1)) bad++;
        end
        check(bad == 0, "R5", {tag, " request spacing mismatches"}, bad, 0);
    endtask

    task automatic set_sc(input int rh, input logic [15:0] caps, input int ca,
                          input logic [31:0] flt, input int lat, input bit poke);
        sc_rst_hold = rh;
        sc_caps     = caps;
        sc_cmp_at   = ca;
        sc_fault    = flt;
        sc_lat      = lat;
        sc_poke     = poke;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0417);
        pend_cnt = 0;
        lg_n = 0;
        set_sc(0, 16'h0, 0, 32'h0, 1, 0);
        repeat (4) @(negedge clk);
        // R1 reset state
        check(busy_o == 0 && done_o == 0 && ok_o == 0 && mgmt_start_o == 0,
              "R1", "outputs in reset", {busy_o, done_o, ok_o, mgmt_start_o}, 0);
        check(code_o == 3'd0, "R1", "code in reset", code_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy_o == 0 && mgmt_start_o == 0 && code_o == 0, "R1", "idle after reset",
              {busy_o, mgmt_start_o}, 0);

        // directed corners
        set_sc(0, 16'hF800, 0, 32'h0, 1, 0);        run_scenario("all abilities, instant");
        set_sc(5, 16'h0000, 3, 32'h0, 2, 1);        run_scenario("reset clears on last read");
        set_sc(6, 16'h5A5A, 0, 32'h0, 1, 0);        run_scenario("R4 reset timeout");
        set_sc(0, 16'h8800, 99, 32'h0, 3, 0);       run_scenario("R11 negotiation timeout");
        set_sc(1, 16'h6000, 4, 32'h6, 1, 1);        run_scenario("R10 faults then ok");
        set_sc(0, 16'h1000, 2, 32'h4, 2, 0);        run_scenario("R9 complete with fault");
        set_sc(0, 16'h2000, 99, 32'h8_0000, 1, 0);  run_scenario("R11 fault on last poll");
        set_sc(0, 16'h07CF, 99, 32'h4_0000, 2, 0);  run_scenario("R11 fault before last");
        set_sc(2, 16'hFFFF, 1, 32'h0, 1, 1);        run_scenario("R7 noisy status");

        // constrained random
        for (int n = 0; n < 16; n++) begin
            set_sc($urandom % 8, 16'($urandom), $urandom % 24,
                   $urandom & $urandom & $urandom, 1 + ($urandom % 3), 1'($urandom % 2));
            run_scenario($sformatf("random %0d", n));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule